// File: doc/BRIEF.md
# SMBus Block Transfer Byte Buffer

This block is a 32-byte staging store that sits behind a single block-data register of an SMBus host controller. Software can load or unload a whole block transfer by repeatedly accessing that one register. It does not need a per-byte handshake with the bus engine. One shared index selects the entry. Every block-data access uses the entry at the index and then moves the index on by one. Reading the control register sets the index back to zero as a side effect.

For a write transfer, software puts the byte count in the count register and then streams the payload through the block-data register. The bus engine then restarts the index and pops bytes in order. It sends the clamped count it finds on `tx_len`. For a read transfer, the engine first writes the received count into the count register and then pushes the data bytes. Software reads the control register to rewind the index and streams the bytes out. `cnt_bad` flags any count outside 1 to 32. An auxiliary register holds the hardware PEC enable bit and the buffer-mode enable bit.

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset the count register reads 0x00, the auxiliary register reads 0x00, every buffer entry holds 0x00, the index is 0, and `pec_en` and `buf_en` are low.
- R2: The register select `sw_sel` is encoded as 0 = control, 1 = count, 2 = block data, 3 = auxiliary. In the auxiliary register, bit 0 is the PEC enable (driven on `pec_en`) and bit 1 is the buffer-mode enable (driven on `buf_en`). Bit 1 can be set only when the `HAS_BUF` parameter is 1; otherwise it reads 0. Bits 7..2 always read 0.
- R3: A software read of the control register returns 0x00 and sets the index to 0 for the next cycle. A software write to the control register changes nothing.
- R4: With buffer mode on, a software write to the block-data register stores the byte at the entry the index points to and advances the index by one.
- R5: With buffer mode on, a software read of the block-data register returns the entry at the index (combinationally, in the same cycle) and advances the index by one.
- R6: The index stops at 32. At that value, block-data writes and engine pushes are dropped, block-data reads and engine pops return 0xFF, and the index stays at 32.
- R7: The count register reads back the last value written. `cnt_bad` is high exactly when the count is 0 or greater than 32.
- R8: `tx_len` equals the count clamped to the range 1 to 32 (0 gives 1, values above 32 give 32).
- R9: `eng_start` sets the index to 0. `eng_push` stores `eng_wdata` at the index and advances it. `eng_pop` presents the entry at the index on `eng_rdata` and advances it. `eng_cnt_we` loads `eng_cnt` into the count register, taking priority over a software write in the same cycle.
- R10: With buffer mode off, the block-data register acts as one plain byte held in entry 0. Software accesses to it do not move the index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr | input | 1 | Software register write strobe |
| sw_rd | input | 1 | Software register read strobe |
| sw_sel | input | 2 | Register select: 0 control, 1 count, 2 block data, 3 auxiliary |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Software read data for the selected register |
| eng_start | input | 1 | Engine transfer start; sets the index to 0 |
| eng_push | input | 1 | Engine stores a received byte |
| eng_pop | input | 1 | Engine takes the next byte to send |
| eng_wdata | input | 8 | Byte pushed by the engine |
| eng_rdata | output | 8 | Byte at the index for the engine |
| eng_cnt_we | input | 1 | Engine writes the received count |
| eng_cnt | input | 8 | Received count from the bus |
| tx_len | output | 6 | Clamped transfer length (1 to 32) |
| cnt_bad | output | 1 | Count is 0 or above 32 |
| pec_en | output | 1 | Hardware PEC enable |
| buf_en | output | 1 | Buffer mode enabled |

## Verification
The hardest state to reach is a saturated index, because the index cannot be read directly. The stimulus fills all 32 entries and pushes past the end. It then rewinds through a control read and reads the whole buffer back. The extra writes must have left every entry intact, and further reads must return 0xFF. Mixed ownership is exercised by letting the engine overwrite part of a buffer that software filled. The bench then pops the whole buffer, so the entries from both sources show up on `eng_rdata` in index order. A full sweep of all 256 count values covers the clamp and the invalid flag.

// File: rtl/smbuf_pkg.sv
package smbuf_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_BLK  = 2'd2,
    SEL_AUX  = 2'd3
  } sel_e;

  // Count outside the legal block length range 1..depth
  function automatic logic cnt_invalid(input logic [7:0] c, input int depth);
    return (c == 8'd0) || (int'(c) > depth);
  endfunction

  // Length the engine sends for a write transfer
  function automatic int clamp_cnt(input logic [7:0] c, input int depth);
    if (c == 8'd0) return 1;
    if (int'(c) > depth) return depth;
    return int'(c);
  endfunction

endpackage

// File: rtl/smbuf_index.sv
module smbuf_index #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] idx,
  output logic          at_end
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH);

  assign at_end = (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx <= '0;
    else if (clr)              idx <= '0;
    else if (adv && !at_end)   idx <= idx + 1'b1;
  end

  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);

  // R3
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == '0));

  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !clr) |=> at_end);

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !at_end) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/smbuf_store.sv
module smbuf_store #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic       in_range;

  assign in_range = (addr < LAST);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mem[g] <= 8'h00;
      else if (we && in_range && addr == IW'(g)) mem[g] <= wdata;
    end
  end

  assign rdata = in_range ? mem[addr[AW-1:0]] : 8'hFF;

  // R6
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> (rdata == 8'hFF));
endmodule

// File: rtl/smbuf_regs.sv
module smbuf_regs #(
  parameter bit HAS_BUF = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_cnt_we,
  input  logic       eng_cnt_we,
  input  logic [7:0] sw_wdata,
  input  logic [7:0] eng_cnt,
  input  logic       sw_aux_we,
  output logic [7:0] cnt_q,
  output logic [7:0] aux_q
);
  localparam logic [7:0] AUX_MASK = {6'b0, HAS_BUF, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 8'h00;
      aux_q <= 8'h00;
    end else begin
      if (eng_cnt_we)      cnt_q <= eng_cnt;
      else if (sw_cnt_we)  cnt_q <= sw_wdata;
      if (sw_aux_we)       aux_q <= sw_wdata & AUX_MASK;
    end
  end

  // R9
  eng_cnt_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cnt_we |=> (cnt_q == $past(eng_cnt)));

  // R7
  sw_cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_cnt_we && !eng_cnt_we) |=> (cnt_q == $past(sw_wdata)));

  // R2
  aux_pec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_aux_we |=> (aux_q[0] == $past(sw_wdata[0])));
endmodule

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf #(
  parameter int DEPTH   = 32,
  parameter bit HAS_BUF = 1'b1,
  localparam int IW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_wr,
  input  logic          sw_rd,
  input  logic [1:0]    sw_sel,
  input  logic [7:0]    sw_wdata,
  output logic [7:0]    sw_rdata,
  input  logic          eng_start,
  input  logic          eng_push,
  input  logic          eng_pop,
  input  logic [7:0]    eng_wdata,
  output logic [7:0]    eng_rdata,
  input  logic          eng_cnt_we,
  input  logic [7:0]    eng_cnt,
  output logic [IW-1:0] tx_len,
  output logic          cnt_bad,
  output logic          pec_en,
  output logic          buf_en
);
  import smbuf_pkg::*;

  logic [7:0]    cnt_q, aux_q, mem_rdata, st_wdata;
  logic [IW-1:0] idx, st_addr;
  logic          at_end, wr_blk, rd_blk, rd_ctrl, clr, adv, eng_acc, st_we;

  assign wr_blk  = sw_wr && (sw_sel == SEL_BLK);
  assign rd_blk  = sw_rd && !sw_wr && (sw_sel == SEL_BLK);
  assign rd_ctrl = sw_rd && !sw_wr && (sw_sel == SEL_CTRL);
  assign eng_acc = eng_push || eng_pop;

  assign clr = eng_start || rd_ctrl;
  assign adv = eng_acc || (buf_en && (wr_blk || rd_blk));

  assign st_we    = eng_push || wr_blk;
  assign st_wdata = eng_push ? eng_wdata : sw_wdata;
  assign st_addr  = (buf_en || eng_acc) ? idx : '0;

  smbuf_index #(.DEPTH(DEPTH)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv),
    .idx(idx), .at_end(at_end)
  );

  smbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .addr(st_addr),
    .wdata(st_wdata), .rdata(mem_rdata)
  );

  smbuf_regs #(.HAS_BUF(HAS_BUF)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .sw_cnt_we(sw_wr && (sw_sel == SEL_CNT)),
    .eng_cnt_we(eng_cnt_we),
    .sw_wdata(sw_wdata), .eng_cnt(eng_cnt),
    .sw_aux_we(sw_wr && (sw_sel == SEL_AUX)),
    .cnt_q(cnt_q), .aux_q(aux_q)
  );

  assign pec_en    = aux_q[0];
  assign buf_en    = aux_q[1];
  assign eng_rdata = mem_rdata;
  assign cnt_bad   = cnt_invalid(cnt_q, DEPTH);
  assign tx_len    = IW'(clamp_cnt(cnt_q, DEPTH));

  always_comb begin
    case (sw_sel)
      SEL_CTRL: sw_rdata = 8'h00;
      SEL_CNT:  sw_rdata = cnt_q;
      SEL_BLK:  sw_rdata = mem_rdata;
      default:  sw_rdata = aux_q;
    endcase
  end

  // R8
  tx_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_len >= IW'(1)) && (tx_len <= IW'(DEPTH)));

  // R6
  sat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_blk && buf_en && at_end) |-> (sw_rdata == 8'hFF));

  // R10
  plain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && !eng_acc && !clr) |=> $stable(idx));
endmodule

// File: tb/sim_smbus_blkbuf.sv
module sim_smbus_blkbuf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_wr = 0, sw_rd = 0, eng_start = 0, eng_push = 0, eng_pop = 0, eng_cnt_we = 0;
  logic [1:0] sw_sel = 0;
  logic [7:0] sw_wdata = 0, eng_wdata = 0, eng_cnt = 0;
  logic [7:0] sw_rdata, eng_rdata, rd1;
  logic [5:0] tx_len;
  logic cnt_bad, pec_en, buf_en;
  logic u1_sw_wr = 0, u1_sw_rd = 0;
  logic [7:0] u1_rdata, u1_er;
  logic [5:0] u1_len;
  logic u1_bad, u1_pec, u1_buf;
  int checks = 0, errors = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  smbus_blkbuf u0 (.clk, .rst_n, .sw_wr, .sw_rd, .sw_sel, .sw_wdata, .sw_rdata,
    .eng_start, .eng_push, .eng_pop, .eng_wdata, .eng_rdata, .eng_cnt_we, .eng_cnt,
    .tx_len, .cnt_bad, .pec_en, .buf_en);

  smbus_blkbuf #(.HAS_BUF(1'b0)) u1 (.clk, .rst_n, .sw_wr(u1_sw_wr), .sw_rd(u1_sw_rd),
    .sw_sel, .sw_wdata, .sw_rdata(u1_rdata), .eng_start(1'b0), .eng_push(1'b0),
    .eng_pop(1'b0), .eng_wdata(8'h00), .eng_rdata(u1_er), .eng_cnt_we(1'b0),
    .eng_cnt(8'h00), .tx_len(u1_len), .cnt_bad(u1_bad), .pec_en(u1_pec), .buf_en(u1_buf));

  function automatic logic [7:0] pat_sw(input int i);
    return 8'((i * 37 + 11) % 256);
  endfunction
  function automatic logic [7:0] pat_eng(input int i);
    return 8'(255 - 3 * i);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); sw_sel = s; sw_wdata = d; sw_wr = 1;
    @(posedge clk); #1 sw_wr = 0;
  endtask

  task automatic sw_read(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); sw_sel = s; sw_rd = 1; #1 d = sw_rdata;
    @(posedge clk); #1 sw_rd = 0;
  endtask

  task automatic eng_op(input int kind, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    case (kind)
      0: eng_start = 1;
      1: begin eng_push = 1; eng_wdata = d; end
      2: eng_pop = 1;
      default: begin eng_cnt_we = 1; eng_cnt = d; end
    endcase
    #1 q = eng_rdata;
    @(posedge clk); #1 {eng_start, eng_push, eng_pop, eng_cnt_we} = 4'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    sw_read(2'd1, rd1); check("R1 count", rd1, 8'h00);
    sw_read(2'd3, rd1); check("R1 aux", rd1, 8'h00);
    check("R1 pec/buf", {6'b0, pec_en, buf_en}, 8'h00);
    sw_write(2'd3, 8'h02);
    for (int i = 0; i < 32; i++) begin sw_read(2'd2, rd1); check("R1 entry", rd1, 8'h00); end
    // R2 auxiliary register
    sw_write(2'd3, 8'hFF); sw_read(2'd3, rd1); check("R2 aux", rd1, 8'h03);
    check("R2 outputs", {6'b0, pec_en, buf_en}, 8'h03);
    @(negedge clk); sw_sel = 2'd3; sw_wdata = 8'h03; u1_sw_wr = 1;
    @(posedge clk); #1 u1_sw_wr = 0;
    @(negedge clk); check("R2 no-buf aux", u1_rdata, 8'h01);
    check("R2 no-buf outputs", {6'b0, u1_pec, u1_buf}, 8'h02);
    // R4 fill, R6 overflow writes dropped
    sw_read(2'd0, rd1); check("R3 ctrl reads zero", rd1, 8'h00);
    for (int i = 0; i < 32; i++) sw_write(2'd2, pat_sw(i));
    sw_write(2'd2, 8'hEE); sw_write(2'd2, 8'hEE);
    sw_read(2'd0, rd1);
    for (int i = 0; i < 32; i++) begin sw_read(2'd2, rd1); check("R5 read back", rd1, pat_sw(i)); end
    sw_read(2'd2, rd1); check("R6 saturated read", rd1, 8'hFF);
    sw_read(2'd2, rd1); check("R6 saturated read again", rd1, 8'hFF);
    // R3 rewind in mid-buffer
    sw_read(2'd0, rd1);
    for (int i = 0; i < 5; i++) sw_write(2'd2, 8'(8'h80 + i));
    sw_read(2'd0, rd1);
    for (int i = 0; i < 6; i++) begin
      sw_read(2'd2, rd1);
      check("R4 partial", rd1, (i < 5) ? 8'(8'h80 + i) : pat_sw(i));
    end
    // R3 control write does not rewind
    sw_write(2'd0, 8'hFF); sw_read(2'd2, rd1); check("R3 ctrl write ignored", rd1, pat_sw(6));
    // R7 R8 count sweep
    for (int c = 0; c < 256; c++) begin
      sw_write(2'd1, 8'(c)); sw_read(2'd1, rd1);
      check("R7 count readback", rd1, 8'(c));
      check("R7 cnt_bad", {7'b0, cnt_bad}, {7'b0, (c < 1) || (c > 32)});
      check("R8 tx_len", {2'b0, tx_len}, 8'((c == 0) ? 1 : ((c > 32) ? 32 : c)));
    end
    // R9 engine fill
    eng_op(0, 8'h00, rd1);
    eng_op(3, 8'd20, rd1);
    sw_read(2'd1, rd1); check("R9 engine count", rd1, 8'd20);
    for (int i = 0; i < 20; i++) eng_op(1, pat_eng(i), rd1);
    @(negedge clk); sw_sel = 2'd1; sw_wdata = 8'h07; sw_wr = 1; eng_cnt_we = 1; eng_cnt = 8'd9;
    @(posedge clk); #1 begin sw_wr = 0; eng_cnt_we = 0; end
    sw_read(2'd1, rd1); check("R9 engine count priority", rd1, 8'd9);
    sw_read(2'd0, rd1);
    for (int i = 0; i < 20; i++) begin sw_read(2'd2, rd1); check("R9 sw sees engine data", rd1, pat_eng(i)); end
    sw_read(2'd2, rd1); check("R9 untouched entry", rd1, pat_sw(20));
    // R9 engine drain
    eng_op(0, 8'h00, rd1);
    for (int i = 0; i < 32; i++) begin
      eng_op(2, 8'h00, rd1);
      v = (i < 20) ? pat_eng(i) : ((i < 5) ? 8'(8'h80 + i) : pat_sw(i));
      check("R9 pop", rd1, v);
    end
    eng_op(2, 8'h00, rd1); check("R6 pop past end", rd1, 8'hFF);
    eng_op(1, 8'h11, rd1);
    eng_op(0, 8'h00, rd1); eng_op(2, 8'h00, rd1); check("R6 push dropped", rd1, pat_eng(0));
    // R10 buffer off
    sw_write(2'd3, 8'h01);
    check("R10 buf off", {7'b0, buf_en}, 8'h00);
    sw_write(2'd2, 8'h5A); sw_write(2'd2, 8'hA5);
    sw_read(2'd2, rd1); check("R10 single byte", rd1, 8'hA5);
    sw_read(2'd2, rd1); check("R10 no advance", rd1, 8'hA5);
    sw_write(2'd3, 8'h02); sw_read(2'd0, rd1);
    sw_read(2'd2, rd1); check("R10 entry0", rd1, 8'hA5);
    sw_read(2'd2, rd1); check("R10 entry1 intact", rd1, pat_eng(1));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule